// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block keeps the control address of a microprogrammed control unit and chooses, on every rising clock edge, the control-memory word used in the following cycle. Each microinstruction supplies a 2-bit test selector, a 2-bit sequencing kind and a 7-bit target address. The block routes one of four sources into the control address register: the current address plus one, the saved return address, the target address, or an entry point derived from the machine opcode.

A one-level return register holds the address after a subroutine call. The current control address drives a 128-word control ROM, which lies outside this block, as does the datapath that produces the status inputs.

Top module: `useq_next_addr`

## Requirements
- R1: A synchronous reset, active high, sets the control address to 64 and the return register to 0. The control address output reads 64 in the cycle after the reset edge.
- R2: The test selector picks the tested condition. Code 0 is constant true. Code 1 is the indirect bit. Code 2 is the accumulator sign. Code 3 is accumulator-equals-zero.
- R3: Sequencing kind 0 is a jump. If the condition is true, the next address is the target field. Otherwise it is the current address plus one.
- R4: Sequencing kind 1 is a call. If the condition is true, the next address is the target field and the return register takes the current address plus one. Otherwise the next address is the current address plus one and the return register is unchanged.
- R5: Sequencing kind 2 is a return. The next address is the return register, whatever the condition.
- R6: Sequencing kind 3 is a map. The next address is {1'b0, opcode[3:0], 2'b00}, whatever the condition.
- R7: The increment wraps modulo 128, so the address after 127 is 0.
- R8: Jump, return and map leave the return register unchanged. Its contents are visible at the output after a later return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_sel | input | 2 | Test selector of the current microinstruction |
| seq_kind | input | 2 | Sequencing kind: 0 jump, 1 call, 2 return, 3 map |
| target | input | 7 | Target address field |
| ind_bit | input | 1 | Indirect status bit |
| acc_neg | input | 1 | Accumulator sign |
| acc_zero | input | 1 | Accumulator equals zero |
| opcode | input | 4 | Machine opcode for the map kind |
| car | output | 7 | Control address that drives the control ROM |

## Verification
A wrong control address is visible at `car` one edge after the fault, because every kind feeds `car` directly. A wrong return register stays hidden until the next return. So every call in the sweep is followed by a return, and the stored value appears at the port within two cycles. The bench sweeps all sequencing kinds, test selectors and status values. It uses several starting addresses, including 127 for the wrap case.

// File: rtl/useq_next_addr.sv
module useq_next_addr #(
  parameter int AW = 7,
  parameter int OPW = 4,
  parameter int RESET_ADDR = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cond_sel,
  input  logic [1:0]    seq_kind,
  input  logic [AW-1:0] target,
  input  logic          ind_bit,
  input  logic          acc_neg,
  input  logic          acc_zero,
  input  logic [OPW-1:0] opcode,
  output logic [AW-1:0] car
);
  localparam int PADL = AW - OPW - 2;

  logic [AW-1:0] ret_q, inc, mapped, nxt;
  logic          test, hi, lo, load_ret;
  logic [1:0]    src;

  always_comb begin
    case (cond_sel)
      2'd0:    test = 1'b1;
      2'd1:    test = ind_bit;
      2'd2:    test = acc_neg;
      default: test = acc_zero;
    endcase
  end

  assign hi       = seq_kind[1];
  assign lo       = seq_kind[0];
  assign src      = {(hi & lo) | (~hi & test), hi};
  assign load_ret = ~hi & lo & test;
  assign inc      = car + 1'b1;
  assign mapped   = {{PADL{1'b0}}, opcode, 2'b00};

  always_comb begin
    case (src)
      2'b00:   nxt = inc;
      2'b01:   nxt = ret_q;
      2'b10:   nxt = target;
      default: nxt = mapped;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      car   <= AW'(RESET_ADDR);
      ret_q <= '0;
    end else begin
      car <= nxt;
      if (load_ret) ret_q <= inc;
    end
  end

  p_reset_addr_r1: assert property (@(posedge clk) rst |=> car == AW'(RESET_ADDR));
  p_ret_target_r5: assert property (@(posedge clk) disable iff (rst)
    seq_kind == 2'd2 |=> car == $past(ret_q));
  p_map_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    seq_kind == 2'd3 |=> car[1:0] == 2'b00 && car[AW-1] == 1'b0);
  p_jump_taken_r3: assert property (@(posedge clk) disable iff (rst)
    (seq_kind == 2'd0 && cond_sel == 2'd0) |=> car == $past(target));
  p_ret_hold_r8: assert property (@(posedge clk) disable iff (rst)
    seq_kind != 2'd1 |=> $stable(ret_q));
  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (seq_kind == 2'd0 && cond_sel == 2'd1 && !ind_bit && car == '1) |=> car == '0);
endmodule

// File: tb/useq_next_addr_tb.sv
module useq_next_addr_tb;
  logic clk = 0, rst = 1;
  logic [1:0] cond_sel = 0, seq_kind = 0;
  logic [6:0] target = 0;
  logic ind_bit = 0, acc_neg = 0, acc_zero = 0;
  logic [3:0] opcode = 0;
  logic [6:0] car;
  int compared = 0, mismatched = 0;
  int m_car, m_ret;
  bit done = 0;

  useq_next_addr u_dut (.clk, .rst, .cond_sel, .seq_kind, .target,
    .ind_bit, .acc_neg, .acc_zero, .opcode, .car);

  always #2 clk = ~clk;

  task automatic check(input string req);
    compared++;
    if (car !== m_car[6:0]) begin
      mismatched++;
      $display("FAIL %s: car=%0d expected %0d", req, car, m_car);
    end
  endtask

  task automatic step(input int k, input int c, input int t, input int i,
                      input int n, input int z, input int op, input string req);
    bit tv;
    seq_kind = 2'(k); cond_sel = 2'(c); target = 7'(t);
    ind_bit = 1'(i); acc_neg = 1'(n); acc_zero = 1'(z); opcode = 4'(op);
    tv = (c == 0) ? 1 : (c == 1) ? i[0] : (c == 2) ? n[0] : z[0];
    case (k)
      0: m_car = tv ? t : (m_car + 1) % 128;
      1: if (tv) begin m_ret = (m_car + 1) % 128; m_car = t; end
         else m_car = (m_car + 1) % 128;
      2: m_car = m_ret;
      default: m_car = op * 4;
    endcase
    @(posedge clk); #1;
    check(req);
  endtask

  initial begin
    #100000; $display("FAIL watchdog: car=%0d expected finish", car);
    mismatched++; compared++; done = 1;
  end

  initial begin
    @(posedge clk); @(posedge clk); #1;
    m_car = 64; m_ret = 0;
    check("R1");
    rst = 0;
    step(2, 0, 0, 0, 0, 0, 0, "R1 ret reg cleared");
    for (int start = 0; start < 4; start++) begin
      for (int k = 0; k < 4; k++)
        for (int c = 0; c < 4; c++)
          for (int s = 0; s < 8; s++) begin
            int st;
            st = (start == 3) ? 127 : start * 37 + 5;
            step(0, 0, st, 0, 0, 0, 0, "R3 setup");
            step(k, c, (k * 13 + c * 29 + s * 7 + 3) % 128, s & 1, (s >> 1) & 1,
                 (s >> 2) & 1, (s + c + start) % 16,
                 k == 0 ? "R2 R3 R7" : k == 1 ? "R2 R4 R7" : k == 2 ? "R5" : "R6");
            step(2, 0, 0, 0, 0, 0, 0, "R8 return reveals ret reg");
          end
    end
    step(0, 0, 127, 0, 0, 0, 0, "R3");
    step(0, 3, 9, 0, 0, 0, 0, "R7 wrap");
    for (int op = 0; op < 16; op++) step(3, 1, 0, 0, 0, 0, op, "R6 all opcodes");
    done = 1;
  end

  initial begin
    wait (done);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule